// File: doc/BRIEF.md
# Dual-Source Raster Scan-Out Fetcher

This block keeps a raster display supplied with pixels from one of two frame stores. The first is a one-bit-per-pixel bitmap in on-chip RAM, read one 32-bit word at a time. The second is a colour frame in external memory, read as 16-byte bursts and holding either 8-bit or 16-bit pixels. Both fetch paths run at all times. A control bit only chooses which path's pixels reach the output.

A CPU writes three registers over a simple write port. Register 0 holds the bitmap base as a byte address. Register 1 holds the colour base as a byte address. Register 2 is control: bit 0 set selects colour, bit 1 set selects 16-bit pixels. The block takes vsync and an active-video strobe from an external timing generator. A write does not act straight away. It is copied into the working configuration on the next vsync rising edge. On that same edge both paths flush their prefetch queues and restart from their bases. Between vsync and the first active pixel, each path fills a small queue, which hides memory latency. If the selected queue is empty during active video, the block raises an underrun flag.

Top module: `scanout_fetcher`

## Requirements
- R1: While reset is high, `pix_valid`, `underrun`, `mono_rd_en` and `burst_req` are 0. After reset, the bitmap base is `MONO_BASE_RST` and the output source is the bitmap.
- R2: Bits 17:2 of the bitmap base give the first RAM word address, so byte bits 1:0 are ignored. Each frame reads consecutive words from there, one word per 32 pixels, `MONO_W*MONO_H/32` words in total.
- R3: Bitmap pixel n of a frame is bit (n mod 32) of the word at offset n/32, so the least significant bit comes first. It appears on `pix_data[0]` with bits 15:1 at zero.
- R4: Bits 3:0 of a colour-base write are ignored. Bursts go to base+16k for k = 0, 1, 2, …, and each frame has `COL_W*COL_H/16` bursts at 8 bpp or `COL_W*COL_H/8` at 16 bpp. A request holds its address until granted.
- R5: At 8 bpp, colour pixel n is byte (n mod 16) of its 16-byte beat, where byte j is `rd_data[8j+7:8j]`. It is zero-extended to 16 bits.
- R6: At 16 bpp, colour pixel n is halfword (n mod 8) of its beat, `rd_data[16j+15:16j]`.
- R7: Register 2 bit 0 chooses the output source (0 for bitmap, 1 for colour). Bit 1 chooses 16 bpp for the colour path.
- R8: A register write changes nothing in the frame under way. It takes effect at the next vsync rising edge, which also restarts both fetch sequences from their bases.
- R9: Each path keeps no more than `FIFO_DEPTH` entries stored or requested. Before the first active pixel, the colour path prefetches exactly `FIFO_DEPTH` bursts when the frame holds at least that many.
- R10: If the selected queue is empty while active is high, the pixel one cycle later has `underrun`=1 and `pix_data`=0. Starvation of the path that is not selected does not affect the output.
- R11: `pix_valid` is `active` delayed by one clock, so every active cycle produces exactly one output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 bitmap base, 1 colour base, 2 control) |
| reg_wdata | input | 24 | Register write data |
| vsync | input | 1 | Vertical sync; its rising edge starts a frame |
| active | input | 1 | Active-video strobe, one pixel per cycle |
| mono_rd_en | output | 1 | Bitmap RAM read enable |
| mono_rd_addr | output | RAM_AW | Bitmap RAM word address |
| mono_rd_data | input | 32 | Bitmap RAM data, one cycle after the read |
| burst_req | output | 1 | External-memory burst request |
| burst_addr | output | 24 | Burst byte address, 16-byte aligned |
| burst_gnt | input | 1 | Burst request accepted |
| rd_valid | input | 1 | Returned 16-byte beat valid, in request order |
| rd_data | input | 128 | Returned beat |
| pix_valid | output | 1 | Output pixel valid |
| pix_data | output | 16 | Output pixel |
| underrun | output | 1 | Pixel was missing from the selected queue |

## Verification
The bench builds the block with a 64x2 bitmap frame and a 32x2 colour frame, a queue depth of 4 and a bitmap reset base of 0x000100. A whole frame is therefore only a handful of words or bursts. This lets every pixel of every frame be compared, and it makes the two queue-depth boundaries reachable. At 8 bpp a full queue holds the whole frame. At 16 bpp it holds exactly one line, so the queue must refill during the line. An external memory with a fixed three-cycle return latency and a stall control covers in-flight data dropped at a frame restart, a request left pending across vsync, and underrun on the selected and unselected paths.

// File: rtl/scanout_pkg.sv
package scanout_pkg;
  localparam logic [1:0] REG_MONO_BASE = 2'd0;
  localparam logic [1:0] REG_COL_BASE  = 2'd1;
  localparam logic [1:0] REG_CTRL      = 2'd2;

  typedef struct packed {
    logic [23:0] mono_base;
    logic [23:0] col_base;
    logic        col_sel;
    logic        depth16;
  } scan_cfg_t;
endpackage

// File: rtl/scan_regs.sv
module scan_regs
  import scanout_pkg::*;
#(
  parameter logic [23:0] MONO_BASE_RST = 24'h000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [23:0] reg_wdata,
  input  logic        vsync,
  output logic        frame_start,
  output scan_cfg_t   cfg
);
  scan_cfg_t shadow;
  logic      vs_q;

  assign frame_start = vsync & ~vs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_q             <= 1'b0;
      shadow.mono_base <= MONO_BASE_RST;
      shadow.col_base  <= 24'h0;
      shadow.col_sel   <= 1'b0;
      shadow.depth16   <= 1'b0;
      cfg.mono_base    <= MONO_BASE_RST;
      cfg.col_base     <= 24'h0;
      cfg.col_sel      <= 1'b0;
      cfg.depth16      <= 1'b0;
    end else begin
      vs_q <= vsync;
      if (reg_we) begin
        case (reg_addr)
          REG_MONO_BASE: shadow.mono_base <= reg_wdata;
          REG_COL_BASE:  shadow.col_base  <= {reg_wdata[23:4], 4'h0};
          REG_CTRL: begin
            shadow.col_sel <= reg_wdata[0];
            shadow.depth16 <= reg_wdata[1];
          end
          default: ;
        endcase
      end
      if (frame_start) cfg <= shadow;
    end
  end

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(cfg));
endmodule

// File: rtl/scan_fifo.sv
module scan_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     cnt
);
  localparam int LOG = $clog2(DEPTH);
  localparam int CW  = LOG + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]   mem [DEPTH];
  logic [LOG-1:0] wp, rp;
  logic           do_push, do_pop;

  assign do_push = push & ~flush;
  assign do_pop  = pop & ~flush & (cnt != '0);
  assign empty   = (cnt == '0);
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (cnt < FULL_CNT || pop || flush));
endmodule

// File: rtl/mono_fetch.sv
module mono_fetch #(
  parameter int RAM_AW = 16,
  parameter int WORDS  = 40500,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [RAM_AW-1:0] base_word,
  input  logic              take,
  output logic              rd_en,
  output logic [RAM_AW-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  output logic              empty,
  output logic              pix
);
  localparam int LOG = $clog2(DEPTH);
  localparam int CW  = LOG + 1;
  localparam int NW  = $clog2(WORDS + 1);

  logic [NW-1:0] word_cnt;
  logic          dv;
  logic [4:0]    idx;
  logic [CW-1:0] cnt;
  logic [CW:0]   used;
  logic [31:0]   head;
  logic          issue, pop;

  assign used  = {1'b0, cnt} + (CW+1)'(rd_en) + (CW+1)'(dv);
  assign issue = !flush && (word_cnt < NW'(WORDS)) && (used < (CW+1)'(DEPTH));
  assign pop   = take && !empty && (idx == 5'd31);
  assign pix   = head[idx];

  scan_fifo #(.W(32), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .flush(flush),
    .push(dv), .din(rd_data), .pop(pop),
    .head(head), .empty(empty), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      dv       <= 1'b0;
      word_cnt <= '0;
      idx      <= '0;
    end else begin
      rd_en <= issue;
      dv    <= rd_en & ~flush;
      if (issue) rd_addr <= base_word + RAM_AW'(word_cnt);
      if (flush)      word_cnt <= '0;
      else if (issue) word_cnt <= word_cnt + 1'b1;
      if (flush)                idx <= '0;
      else if (take && !empty)  idx <= idx + 1'b1;
    end
  end

  // R9
  mono_credit_chk: assert property (@(posedge clk) disable iff (rst)
    used <= (CW+1)'(DEPTH));
endmodule

// File: rtl/color_fetch.sv
module color_fetch #(
  parameter int DEPTH    = 4,
  parameter int BURSTS8  = 49152,
  parameter int BURSTS16 = 98304
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic [23:0]  base,
  input  logic         depth16,
  input  logic         take,
  output logic         burst_req,
  output logic [23:0]  burst_addr,
  input  logic         burst_gnt,
  input  logic         rd_valid,
  input  logic [127:0] rd_data,
  output logic         empty,
  output logic [15:0]  pix
);
  localparam int LOG = $clog2(DEPTH);
  localparam int CW  = LOG + 1;
  localparam int IW  = LOG + 2;
  localparam int BW  = $clog2(BURSTS16 + 1);

  logic [BW-1:0]  burst_cnt, limit;
  logic [IW-1:0]  inflight, drop, total, live;
  logic [IW:0]    used;
  logic [CW-1:0]  cnt;
  logic [127:0]   head;
  logic [3:0]     idx;
  logic           acc, can_issue, push, pop, last;

  assign acc       = burst_req & burst_gnt;
  assign total     = inflight + IW'(acc) - IW'(rd_valid);
  assign live      = inflight - drop;
  assign used      = {1'b0, live} + (IW+1)'(cnt) + (IW+1)'(burst_req);
  assign limit     = depth16 ? BW'(BURSTS16) : BW'(BURSTS8);
  assign can_issue = !flush && !burst_req && (burst_cnt < limit) && (used < (IW+1)'(DEPTH));
  assign push      = rd_valid && (drop == '0);
  assign last      = depth16 ? (idx == 4'd7) : (idx == 4'd15);
  assign pop       = take && !empty && last;
  assign pix       = depth16 ? head[{idx[2:0], 4'b0} +: 16]
                             : {8'h00, head[{idx, 3'b0} +: 8]};

  scan_fifo #(.W(128), .DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .flush(flush),
    .push(push), .din(rd_data), .pop(pop),
    .head(head), .empty(empty), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_req  <= 1'b0;
      burst_addr <= '0;
      burst_cnt  <= '0;
      inflight   <= '0;
      drop       <= '0;
      idx        <= '0;
    end else begin
      inflight <= total;
      if (flush) begin
        burst_req <= 1'b0;
        burst_cnt <= '0;
        drop      <= total;
      end else begin
        if (acc) begin
          burst_req <= 1'b0;
          burst_cnt <= burst_cnt + 1'b1;
        end else if (can_issue) begin
          burst_req  <= 1'b1;
          burst_addr <= base + 24'({burst_cnt, 4'h0});
        end
        if (rd_valid && drop != '0) drop <= drop - 1'b1;
      end
      if (flush || pop)         idx <= '0;
      else if (take && !empty)  idx <= idx + 1'b1;
    end
  end

  // R4
  burst_align_chk: assert property (@(posedge clk) disable iff (rst)
    burst_req |-> (burst_addr[3:0] == 4'h0));
  // R4
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (burst_req && !burst_gnt && !flush) |=> (burst_req && $stable(burst_addr)));
  // R9
  color_credit_chk: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, live} + (IW+1)'(cnt)) <= (IW+1)'(DEPTH));
endmodule

// File: rtl/scanout_fetcher.sv
module scanout_fetcher
  import scanout_pkg::*;
#(
  parameter int          MONO_W        = 1440,
  parameter int          MONO_H        = 900,
  parameter int          COL_W         = 1024,
  parameter int          COL_H         = 768,
  parameter int          RAM_AW        = 16,
  parameter int          FIFO_DEPTH    = 4,
  parameter logic [23:0] MONO_BASE_RST = 24'h000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [23:0]       reg_wdata,
  input  logic              vsync,
  input  logic              active,
  output logic              mono_rd_en,
  output logic [RAM_AW-1:0] mono_rd_addr,
  input  logic [31:0]       mono_rd_data,
  output logic              burst_req,
  output logic [23:0]       burst_addr,
  input  logic              burst_gnt,
  input  logic              rd_valid,
  input  logic [127:0]      rd_data,
  output logic              pix_valid,
  output logic [15:0]       pix_data,
  output logic              underrun
);
  localparam int MONO_WORDS = MONO_W * MONO_H / 32;
  localparam int BURSTS8    = COL_W * COL_H / 16;
  localparam int BURSTS16   = COL_W * COL_H / 8;

  scan_cfg_t   cfg;
  logic        frame_start;
  logic        m_empty, m_pix, c_empty, sel_empty;
  logic [15:0] c_pix, sel_pix;
  logic        unused_base_bits;

  assign unused_base_bits = ^{cfg.mono_base[1:0], cfg.mono_base[23:RAM_AW+2]};

  scan_regs #(.MONO_BASE_RST(MONO_BASE_RST)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vsync(vsync),
    .frame_start(frame_start), .cfg(cfg)
  );

  mono_fetch #(.RAM_AW(RAM_AW), .WORDS(MONO_WORDS), .DEPTH(FIFO_DEPTH)) u_mono (
    .clk(clk), .rst(rst), .flush(frame_start),
    .base_word(cfg.mono_base[RAM_AW+1:2]), .take(active),
    .rd_en(mono_rd_en), .rd_addr(mono_rd_addr), .rd_data(mono_rd_data),
    .empty(m_empty), .pix(m_pix)
  );

  color_fetch #(.DEPTH(FIFO_DEPTH), .BURSTS8(BURSTS8), .BURSTS16(BURSTS16)) u_col (
    .clk(clk), .rst(rst), .flush(frame_start),
    .base(cfg.col_base), .depth16(cfg.depth16), .take(active),
    .burst_req(burst_req), .burst_addr(burst_addr), .burst_gnt(burst_gnt),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .empty(c_empty), .pix(c_pix)
  );

  assign sel_empty = cfg.col_sel ? c_empty : m_empty;
  assign sel_pix   = cfg.col_sel ? c_pix : {15'h0000, m_pix};

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
      underrun  <= 1'b0;
    end else begin
      pix_valid <= active;
      underrun  <= active & sel_empty;
      pix_data  <= (active && !sel_empty) ? sel_pix : 16'h0000;
    end
  end

  // R10
  underrun_blank_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> (pix_valid && pix_data == 16'h0000));
endmodule

// File: tb/test_scanout_fetcher.sv
module test_scanout_fetcher;
  localparam int MW = 64, MH = 2, CWD = 32, CH = 2, AW = 16, DEP = 4;
  localparam logic [23:0] MBASE = 24'h000100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic vsync = 1'b0, active = 1'b0;
  logic mono_rd_en;
  logic [AW-1:0] mono_rd_addr;
  logic [31:0] mono_rd_data;
  logic burst_req, burst_gnt, rd_valid;
  logic [23:0] burst_addr;
  logic [127:0] rd_data;
  logic pix_valid, underrun;
  logic [15:0] pix_data;
  logic mem_stall = 1'b0;

  int n_tests = 0, n_fail = 0;
  int ncap = 0, n_bursts = 0, n_mono = 0;
  int f_start, f_pre, f_bursts, f_mono;
  logic [15:0] cap_pix [0:4095];
  logic        cap_und [0:4095];

  always #10 clk = ~clk;

  scanout_fetcher #(
    .MONO_W(MW), .MONO_H(MH), .COL_W(CWD), .COL_H(CH),
    .RAM_AW(AW), .FIFO_DEPTH(DEP), .MONO_BASE_RST(MBASE)
  ) i_scanout_fetcher (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .vsync(vsync), .active(active),
    .mono_rd_en(mono_rd_en), .mono_rd_addr(mono_rd_addr), .mono_rd_data(mono_rd_data),
    .burst_req(burst_req), .burst_addr(burst_addr), .burst_gnt(burst_gnt),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .pix_valid(pix_valid), .pix_data(pix_data), .underrun(underrun)
  );

  function automatic logic [31:0] ramword(input logic [15:0] a);
    return {a, ~a} ^ 32'h5A3C96E1;
  endfunction

  function automatic logic [7:0] ebyte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [127:0] beat(input logic [23:0] a);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = ebyte(a + 24'(k));
    return r;
  endfunction

  function automatic logic [15:0] mono_exp(input logic [23:0] b, input int n);
    logic [15:0] w;
    logic [31:0] d;
    w = b[17:2] + 16'(n / 32);
    d = ramword(w);
    return {15'h0, d[n % 32]};
  endfunction

  function automatic logic [15:0] col_exp(input logic [23:0] b, input bit d16, input int n);
    if (d16) return {ebyte(b + 24'(2*n+1)), ebyte(b + 24'(2*n))};
    return {8'h00, ebyte(b + 24'(n))};
  endfunction

  // memory models: registered, one-cycle RAM and three-cycle burst return
  assign burst_gnt = burst_req & ~mem_stall;
  logic        lv0, lv1, lv2;
  logic [23:0] la0, la1, la2;
  always @(posedge clk) begin
    mono_rd_data <= ramword(mono_rd_addr);
    if (rst) begin
      lv0 <= 1'b0; lv1 <= 1'b0; lv2 <= 1'b0; rd_valid <= 1'b0;
    end else begin
      lv0 <= burst_req & burst_gnt; la0 <= burst_addr;
      lv1 <= lv0; la1 <= la0;
      lv2 <= lv1; la2 <= la1;
      rd_valid <= lv2;
    end
    rd_data <= beat(la2);
  end

  always @(negedge clk) begin
    if (pix_valid) begin
      cap_pix[ncap] = pix_data;
      cap_und[ncap] = underrun;
      ncap = ncap + 1;
    end
    if (burst_req && burst_gnt) n_bursts = n_bursts + 1;
    if (mono_rd_en) n_mono = n_mono + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_frame(input int w, input int h, input bit mid_we,
                           input logic [1:0] ma, input logic [23:0] md);
    int b0, m0;
    @(negedge clk);
    f_start = ncap; b0 = n_bursts; m0 = n_mono;
    vsync = 1'b1;
    repeat (2) @(negedge clk);
    vsync = 1'b0;
    repeat (4) @(negedge clk);
    if (mid_we) reg_write(ma, md);
    repeat (20) @(negedge clk);
    @(posedge clk);
    f_pre = n_bursts - b0;
    @(negedge clk);
    for (int l = 0; l < h; l++) begin
      active = 1'b1;
      repeat (w) @(negedge clk);
      active = 1'b0;
      repeat (12) @(negedge clk);
    end
    @(posedge clk);
    f_bursts = n_bursts - b0;
    f_mono = n_mono - m0;
    @(negedge clk);
  endtask

  task automatic check_frame(input bit colour, input logic [23:0] b, input bit d16,
                             input int npix, input string tag);
    int errs = 0, uerr = 0;
    logic [15:0] fa = '0, fe = '0;
    check(ncap - f_start == npix, "R11 one output pixel per active cycle",
          32'(ncap - f_start), 32'(npix));
    for (int n = 0; n < npix; n++) begin
      logic [15:0] e;
      e = colour ? col_exp(b, d16, n) : mono_exp(b, n);
      if (cap_und[f_start+n]) uerr++;
      if (cap_pix[f_start+n] !== e) begin
        if (errs == 0) begin fa = cap_pix[f_start+n]; fe = e; end
        errs++;
      end
    end
    check(errs == 0, tag, 32'(fa), 32'(fe));
    check(uerr == 0, "R10 no underrun when the queue is fed", 32'(uerr), 0);
  endtask

  task automatic t_reset_default();
    check(pix_valid == 1'b0 && underrun == 1'b0, "R1 outputs low in reset",
          {30'h0, pix_valid, underrun}, 0);
    check(mono_rd_en == 1'b0 && burst_req == 1'b0, "R1 no fetch in reset",
          {30'h0, mono_rd_en, burst_req}, 0);
    @(negedge clk); rst = 1'b0;
    run_frame(MW, MH, 1'b0, 2'd0, 24'h0);
    check_frame(1'b0, MBASE, 1'b0, MW*MH, "R1 R3 default bitmap base, LSB-first pixels");
  endtask

  task automatic t_mono_relocate();
    reg_write(2'd0, 24'h000A07);
    run_frame(MW, MH, 1'b0, 2'd0, 24'h0);
    check_frame(1'b0, 24'h000A04, 1'b0, MW*MH, "R2 R3 relocated bitmap pixels");
    check(f_mono == MW*MH/32, "R2 one word read per 32 pixels", 32'(f_mono), 32'(MW*MH/32));
  endtask

  task automatic t_color8();
    reg_write(2'd1, 24'h01234F);
    reg_write(2'd2, 24'h000001);
    run_frame(CWD, CH, 1'b0, 2'd0, 24'h0);
    check_frame(1'b1, 24'h012340, 1'b0, CWD*CH, "R4 R5 R7 colour 8bpp pixels from aligned base");
    check(f_bursts == CWD*CH/16, "R4 bursts per 8bpp frame", 32'(f_bursts), 32'(CWD*CH/16));
  endtask

  task automatic t_color16();
    reg_write(2'd2, 24'h000003);
    run_frame(CWD, CH, 1'b0, 2'd0, 24'h0);
    check_frame(1'b1, 24'h012340, 1'b1, CWD*CH, "R6 colour 16bpp halfwords");
    check(f_bursts == CWD*CH/8, "R4 bursts per 16bpp frame", 32'(f_bursts), 32'(CWD*CH/8));
    check(f_pre == DEP, "R9 prefetch depth before active", 32'(f_pre), 32'(DEP));
  endtask

  task automatic t_deferred();
    run_frame(CWD, CH, 1'b1, 2'd2, 24'h000000);
    check_frame(1'b1, 24'h012340, 1'b1, CWD*CH, "R8 mid-frame write leaves frame unchanged");
    run_frame(MW, MH, 1'b0, 2'd0, 24'h0);
    check_frame(1'b0, 24'h000A04, 1'b0, MW*MH, "R8 R7 write applied at next vsync");
  endtask

  task automatic t_underrun();
    int ucnt = 0, nz = 0;
    reg_write(2'd2, 24'h000001);
    mem_stall = 1'b1;
    run_frame(CWD, CH, 1'b0, 2'd0, 24'h0);
    for (int n = 0; n < CWD*CH; n++) begin
      if (cap_und[f_start+n]) ucnt++;
      if (cap_pix[f_start+n] != 16'h0) nz++;
    end
    check(ncap - f_start == CWD*CH, "R11 pixel count during underrun",
          32'(ncap - f_start), 32'(CWD*CH));
    check(ucnt == CWD*CH, "R10 underrun flagged on starved colour path", 32'(ucnt), 32'(CWD*CH));
    check(nz == 0, "R10 blank pixels on underrun", 32'(nz), 0);
    reg_write(2'd2, 24'h000000);
    run_frame(MW, MH, 1'b0, 2'd0, 24'h0);
    check_frame(1'b0, 24'h000A04, 1'b0, MW*MH, "R10 unselected colour starvation has no effect");
    mem_stall = 1'b0;
    reg_write(2'd2, 24'h000001);
    run_frame(CWD, CH, 1'b0, 2'd0, 24'h0);
    run_frame(CWD, CH, 1'b0, 2'd0, 24'h0);
    check_frame(1'b1, 24'h012340, 1'b0, CWD*CH, "R8 R5 colour restart after stall");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_default();
    t_mono_relocate();
    t_color8();
    t_color16();
    t_deferred();
    t_underrun();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule